// File: doc/BRIEF.md
# Tuning Synthesiser Serial Command Port

This block is the two-wire serial slave in front of a tuning frequency synthesiser. It samples the clock and data lines with the system clock and recognises start and stop conditions. It compares the address byte against a device address whose two lowest bits are strapped from an address-select input, so that up to four synthesisers can share one bus. The last bit of the address byte then puts the transaction in write or read mode.

In write mode, data bytes arrive in pairs. The top bit of the first byte of a pair picks its destination: a zero opens a frequency pair, which loads a 15-bit divide ratio. A one opens a control pair, which loads a 7-bit control field and a 6-bit port-output field. New values are committed only after the second byte of a pair has been received in full. Pairs may repeat until a stop.

In read mode the block returns a status byte that reports the power-on flag, the lock flag, three port levels and a 3-bit converter code. It sends another status byte each time the master acknowledges. A missing master acknowledge ends the read with an internal stop. The block drives the data line only low, through an open-drain enable.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The device address is {BASE_ADDR[6:2], addr_sel[1:0]} (default base 7'h60). On an address byte {address, rw}, the block pulls SDA low in the acknowledge slot only when the 7 address bits match. On a mismatch it acknowledges neither that byte nor any later byte until a new start.
- R2: In write mode (rw = 0), every data byte gets an acknowledge.
- R3: A first-of-pair byte with bit 7 = 0 starts a frequency pair, and the next byte completes it. After the second byte, divide_ratio = {first[6:0], second[7:0]}.
- R4: A first-of-pair byte with bit 7 = 1 starts a control pair. After the second byte, ctrl_bits = first[6:0] and port_on = second[5:0]. Bits 7:6 of the second byte are ignored. Bit 0 drives P0, and bits 1 to 5 drive P3 to P7; 1 means on.
- R5: Any number of pairs, of either kind, may follow one address byte without readdressing.
- R6: When a start or stop arrives partway through a byte or between the two bytes of a pair, the registers keep their previous values, and the next byte counts as a first-of-pair byte.
- R7: In read mode (rw = 1), the status byte goes out MSB first as {por_flag, lock, port_lvl[2] (P7), port_lvl[1] (P5), port_lvl[0] (P4), adc_code[2:0]}. It is sampled when its first bit is put on the bus.
- R8: A master acknowledge after a status byte produces another status byte. A master non-acknowledge releases SDA, and the block ignores further clocks until a new start.
- R9: por_flag is 1 after reset and after a supply_lost pulse. That same event clears divide_ratio, ctrl_bits and port_on to 0. A stop that ends a transaction containing a read clears por_flag.
- R10: sda_oe changes only on a falling SCL edge, or when it is released at a start or stop, and it is 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Low two bits of the device address |
| supply_lost | input | 1 | Supply-loss event, sets POR |
| lock | input | 1 | Phase lock indication |
| port_lvl | input | 3 | Levels of ports P7, P5, P4 |
| adc_code | input | 3 | Converter code for status |
| divide_ratio | output | 15 | Programmed divider ratio |
| ctrl_bits | output | 7 | Control field from the control pair |
| port_on | output | 6 | Port enables P7,P6,P5,P4,P3,P0 (bit 5 down to bit 0) |
| por_flag | output | 1 | Power-on reset indicator |

## Verification
The hardest states to reach from the ports are the aborted ones. One is a transfer cut off by a stop after three bits of a byte. The other is a transfer cut off after only the first byte of a pair. Both need the bus master model to break the framing on purpose. The directed tasks do this by issuing start and stop at chosen bit counts and then reading back the unchanged ratio. The internal stop after a master non-acknowledge is reached by clocking a further read byte with no new start and checking that the line stays high throughout.

// File: rtl/tuner_pkg.sv
// Shared types for the synthesiser serial command port.
package tuner_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA, ST_WR_ACK, ST_RD_DATA, ST_RD_ACK
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronises SCL/SDA into the clock domain and flags edges and bus conditions.
// Assumes SCL is slow compared with clk (several clocks per phase).
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_d, sda_d;

    // Shift both lines through the synchroniser chain and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Decode edges and start/stop from the current and previous samples.
    always_comb begin
        sda_s     = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_sync[SYNC_STAGES-1] & ~scl_d;
        scl_fall  = ~scl_sync[SYNC_STAGES-1] & scl_d;
        start_det = scl_sync[SYNC_STAGES-1] & scl_d & sda_d & ~sda_s;
        stop_det  = scl_sync[SYNC_STAGES-1] & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_slave_engine.sv
// Bit/byte sequencer: address match, acknowledges, write byte strobes,
// status shifting and the internal stop after a master non-acknowledge.
// Assumes edge/condition inputs are single-cycle pulses.
module i2c_slave_engine
    import tuner_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              por_clr
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw, rd_txn, m_ack;

    // Main bus sequencer; every data-line change happens on a falling SCL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            sda_oe <= 1'b0;
            rw     <= 1'b0;
            rd_txn <= 1'b0;
            m_ack  <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            rd_txn <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (state == ST_WR_DATA) begin
                            state  <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                        end else if (sh[BYTE_W-1:1] == dev_addr) begin
                            state  <= ST_ADDR_ACK;
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            state  <= ST_RD_DATA;
                            sh     <= status;
                            sda_oe <= ~status[BYTE_W-1];
                            rd_txn <= 1'b1;
                        end else begin
                            state  <= ST_WR_DATA;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state  <= ST_WR_DATA;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == FULL) begin
                            state  <= ST_RD_ACK;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            state  <= ST_RD_DATA;
                            sh     <= status;
                            sda_oe <= ~status[BYTE_W-1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Byte strobe to the register bank and the read-ending stop pulse.
    always_comb begin
        byte_stb  = (state == ST_WR_DATA) && scl_fall && (cnt == FULL) && !start_det && !stop_det;
        byte_data = sh;
        por_clr   = stop_det && rd_txn;
    end
endmodule

// File: rtl/tuner_cmd_regs.sv
// Pairs incoming write bytes and commits divide ratio or control/port fields
// once a pair is complete; owns the power-on flag.
// Assumes byte_stb is a one-cycle pulse per received data byte.
module tuner_cmd_regs #(
    parameter int RATIO_W = 15,
    parameter int CTRL_W  = 7,
    parameter int PORT_W  = 6,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_lost,
    input  logic               seq_reset,
    input  logic               byte_stb,
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic               por_clr,
    output logic [RATIO_W-1:0] divide_ratio,
    output logic [CTRL_W-1:0]  ctrl_bits,
    output logic [PORT_W-1:0]  port_on,
    output logic               por_flag
);
    localparam int HI_W = RATIO_W - BYTE_W;

    logic              second_due;
    logic [BYTE_W-1:0] first_q;

    // Hold the first byte of a pair, commit on the second, clear on supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_lost) begin
            divide_ratio <= '0;
            ctrl_bits    <= '0;
            port_on      <= '0;
            second_due   <= 1'b0;
            first_q      <= '0;
            por_flag     <= 1'b1;
        end else begin
            if (por_clr) por_flag <= 1'b0;
            if (seq_reset) begin
                second_due <= 1'b0;
            end else if (byte_stb) begin
                if (!second_due) begin
                    first_q    <= byte_data;
                    second_due <= 1'b1;
                end else begin
                    second_due <= 1'b0;
                    if (first_q[BYTE_W-1]) begin
                        ctrl_bits <= first_q[CTRL_W-1:0];
                        port_on   <= byte_data[PORT_W-1:0];
                    end else begin
                        divide_ratio <= {first_q[HI_W-1:0], byte_data};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_ctrl.sv
// Top of the synthesiser serial command port: line sampler, slave sequencer
// and command register bank. SDA is driven low only, via sda_oe.
module tuner_i2c_ctrl #(
    parameter logic [6:0] BASE_ADDR   = 7'h60,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [1:0]  addr_sel,
    input  logic        supply_lost,
    input  logic        lock,
    input  logic [2:0]  port_lvl,
    input  logic [2:0]  adc_code,
    output logic [14:0] divide_ratio,
    output logic [6:0]  ctrl_bits,
    output logic [5:0]  port_on,
    output logic        por_flag
);
    logic       scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic       byte_stb, por_clr;
    logic [7:0] byte_data, status;
    logic [6:0] dev_addr;

    // Form the strapped address and the live status byte.
    always_comb begin
        dev_addr = {BASE_ADDR[6:2], addr_sel};
        status   = {por_flag, lock, port_lvl, adc_code};
    end

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    i2c_slave_engine #(.ADDR_W(7), .BYTE_W(8)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .dev_addr(dev_addr), .status(status), .sda_oe(sda_oe),
        .byte_stb(byte_stb), .byte_data(byte_data), .por_clr(por_clr)
    );

    tuner_cmd_regs #(.RATIO_W(15), .CTRL_W(7), .PORT_W(6), .BYTE_W(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .supply_lost(supply_lost),
        .seq_reset(start_det | stop_det), .byte_stb(byte_stb),
        .byte_data(byte_data), .por_clr(por_clr),
        .divide_ratio(divide_ratio), .ctrl_bits(ctrl_bits),
        .port_on(port_on), .por_flag(por_flag)
    );
endmodule

// File: rtl/tuner_i2c_ctrl_chk.sv
// Property checker for the serial command port, bound into the top module.
module tuner_i2c_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        supply_lost,
    input logic        sda_oe,
    input logic        por_flag,
    input logic [14:0] divide_ratio,
    input logic [5:0]  port_on
);
    // R6: the ratio moves only on a falling SCL or a supply loss
    a_r6_ratio_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !supply_lost) |=> $stable(divide_ratio));

    // R4: the port field moves only on a falling SCL or a supply loss
    a_r4_ports_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !supply_lost) |=> $stable(port_on));

    // R10: the data drive changes only on a falling SCL or at a start/stop
    a_r10_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));

    // R10: a stop always leaves the line released
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R9: POR only rises after a supply loss
    a_r9_por_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_flag) |-> $past(supply_lost));

    // R9: POR only falls at a stop
    a_r9_por_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(stop_det));

    // R9: a supply loss clears the programmed data
    a_r9_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lost |=> (por_flag && divide_ratio == '0 && port_on == '0));
endmodule

bind tuner_i2c_ctrl tuner_i2c_ctrl_chk u_chk (.*);

// File: tb/tuner_i2c_ctrl_test.sv
// Directed bench for the serial command port: one task per scenario.
module tuner_i2c_ctrl_test;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b01;
    logic        supply_lost = 1'b0;
    logic        lock = 1'b1;
    logic [2:0]  port_lvl = 3'b101;
    logic [2:0]  adc_code = 3'b011;
    logic        sda_oe, por_flag;
    logic [14:0] divide_ratio;
    logic [6:0]  ctrl_bits;
    logic [5:0]  port_on;
    logic        sda_line;
    int          n_chk = 0;
    int          n_bad = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    tuner_i2c_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .supply_lost(supply_lost),
        .lock(lock), .port_lvl(port_lvl), .adc_code(adc_code),
        .divide_ratio(divide_ratio), .ctrl_bits(ctrl_bits),
        .port_on(port_on), .por_flag(por_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        check("R9 por after reset", por_flag, 1);
        check("R9 ratio after reset", divide_ratio, 0);
        check("R9 ports after reset", port_on, 0);
        check("R10 idle release", sda_oe, 0);
    endtask

    task automatic t_read_status();
        logic a; logic [7:0] d;
        bus_start(); put_byte(8'hC3, a);
        check("R1 read address ack", a, 1);
        get_byte(1'b1, d);
        check("R7 status with por set", d, 8'hEB);
        get_byte(1'b0, d);
        check("R8 repeat status after master ack", d, 8'hEB);
        get_byte(1'b0, d);
        check("R8 released after master nack", d, 8'hFF);
        bus_stop();
        check("R9 por cleared by read stop", por_flag, 0);
        lock = 1'b0; port_lvl = 3'b010; adc_code = 3'b100;
        bus_start(); put_byte(8'hC3, a); get_byte(1'b0, d); bus_stop();
        check("R7 status after inputs change", d, 8'h14);
    endtask

    task automatic t_addr_mismatch();
        logic a;
        bus_start(); put_byte(8'hC4, a);
        check("R1 foreign address not acked", a, 0);
        put_byte(8'h12, a);
        check("R1 no ack after mismatch", a, 0);
        put_byte(8'h34, a); bus_stop();
        check("R1 no write after mismatch", divide_ratio, 0);
    endtask

    task automatic t_freq_pair();
        logic a0, a1, a2;
        bus_start(); put_byte(8'hC2, a0); put_byte(8'h12, a1); put_byte(8'h34, a2); bus_stop();
        check("R2 data bytes acked", {a0, a1, a2}, 3'b111);
        check("R3 ratio from frequency pair", divide_ratio, 15'h1234);
    endtask

    task automatic t_ctrl_pair();
        logic a;
        bus_start(); put_byte(8'hC2, a); put_byte(8'h85, a); put_byte(8'hFF, a); bus_stop();
        check("R4 control field", ctrl_bits, 7'h05);
        check("R4 ports, top bits ignored", port_on, 6'h3F);
        check("R4 ratio untouched by control pair", divide_ratio, 15'h1234);
    endtask

    task automatic t_multi_pairs();
        logic a;
        bus_start(); put_byte(8'hC2, a);
        put_byte(8'h7F, a); put_byte(8'hFF, a);
        check("R5 first pair committed", divide_ratio, 15'h7FFF);
        put_byte(8'hAA, a); put_byte(8'h15, a);
        put_byte(8'h01, a); put_byte(8'h00, a);
        bus_stop();
        check("R5 later frequency pair", divide_ratio, 15'h0100);
        check("R5 later control field", ctrl_bits, 7'h2A);
        check("R5 later port field", port_on, 6'h15);
    endtask

    task automatic t_abort();
        logic a, s;
        bus_start(); put_byte(8'hC2, a); put_byte(8'h55, a);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
        bus_stop();
        check("R6 mid-byte stop keeps ratio", divide_ratio, 15'h0100);
        bus_start(); put_byte(8'hC2, a); put_byte(8'h55, a); bus_stop();
        check("R6 half pair keeps ratio", divide_ratio, 15'h0100);
        bus_start(); put_byte(8'hC2, a); put_byte(8'h22, a); put_byte(8'h33, a); bus_stop();
        check("R6 next byte starts a fresh pair", divide_ratio, 15'h2233);
    endtask

    task automatic t_supply_loss();
        @(posedge clk); #1 supply_lost = 1'b1;
        @(posedge clk); #1 supply_lost = 1'b0;
        wq();
        check("R9 por set by supply loss", por_flag, 1);
        check("R9 ratio cleared by supply loss", divide_ratio, 0);
        check("R9 ports cleared by supply loss", port_on, 0);
        check("R10 idle release after loss", sda_oe, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk); #1 rst_n = 1'b1;
        wq();
        t_reset();
        t_read_status();
        t_addr_mismatch();
        t_freq_pair();
        t_ctrl_pair();
        t_multi_pairs();
        t_abort();
        t_supply_loss();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule